// File: doc/BRIEF.md
# Trellis path-metric update unit (four-state, rate 1/2)

This unit keeps the accumulated path metric of every state of a four-state trellis. The trellis belongs to a rate 1/2 convolutional code with constraint length 3 and generator taps 7 and 5 (octal). For each accepted symbol it takes four branch metrics, one per possible coded output pair. For every next state it forms the two candidate metrics from its two predecessor states, keeps the smaller one, and records which predecessor won. A branch-metric stage sits upstream and a traceback stage sits downstream. The unit sits between them and hands the traceback stage one survivor bit per state and the index of the currently best state.

Metrics are renormalised on every step so that the register width stays bounded. Unreachable states are pinned at the largest representable value through saturating additions. A mode input selects how frame boundaries are handled. In continuous mode, metrics flow from frame to frame and an explicit restart input reinitialises them. In the two independent-frame modes, a frame-start flag reinitialises them instead.

Top module: `vit_acs_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stored metrics become the initial pattern and `out_valid_o` becomes 0. In the initial pattern, state 0 holds 0 and every other state holds MAX = 2^SMW-1.
- R2: For next state s, the candidate predecessors are p0 = (2*s) mod 4 and p1 = p0+1. The branch metric of a transition is taken from `bm_i[BMW*c +: BMW]`, where c = {c0,c1}. Here c0 is the XOR of the input bit and both register bits (taps 7), and c1 is the XOR of the input bit and the older register bit (taps 5). The input bit is s[1], and the register bits are s[0] and the predecessor LSB. Each state keeps the smaller candidate.
- R3: Decision bit s of `dec_o` is 1 when the candidate from p1 is strictly smaller, and 0 otherwise, so ties choose p0.
- R4: Additions saturate at MAX, so a state whose two predecessors both hold MAX holds MAX after the step.
- R5: After each step, the smallest selected metric is subtracted from every selected metric that is not MAX, so at least one state holds 0. A long run cannot overflow.
- R6: `best_o` is the index of the smallest metric; on a tie the lowest index wins.
- R7: `out_valid_o`, `dec_o`, `best_o` and the new metrics appear on the clock edge at which `valid_i` is sampled high. With `valid_i` low, the metrics hold and `out_valid_o` is 0.
- R8: In continuous mode (`mode_i` = 0), `frame_start_i` is ignored and metrics carry over between frames.
- R9: In truncated (`mode_i` = 1) or terminated (`mode_i` = 2) mode, the metrics used as predecessors are the initial pattern on a valid symbol with `frame_start_i` high. Any other mode value is treated in the same way.
- R10: `restart_i` reinitialises the predecessor metrics on a valid symbol only in continuous mode, and is ignored in the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Branch metrics valid this cycle |
| mode_i | input | 2 | 0 continuous, 1 truncated, 2 terminated |
| frame_start_i | input | 1 | First symbol of a frame (independent-frame modes) |
| restart_i | input | 1 | Reinitialise metrics (continuous mode only) |
| bm_i | input | 4*BMW | Branch metric per coded pair, code c at slice c |
| out_valid_o | output | 1 | Outputs updated by the previous symbol |
| dec_o | output | 4 | Survivor decision bit per state |
| best_o | output | 2 | Index of the smallest metric |
| metrics_o | output | 4*SMW | Stored metric per state, state s at slice s |

## Verification
A fixed sequence of hard-decision received pairs, with branch metrics formed as Hamming distances, is driven from reset. The sequence yields all-zero decisions, all-one decisions and a mixed decision word, which separates a swapped predecessor or a wrong branch label from a correct one. One step gives a nonzero minimum, so renormalisation and lowest-index tie breaking of the best state become visible. The same symbols are replayed with frame-start and restart raised under each mode, to show which flag reinitialises metrics in which mode. A long run of equal large branch metrics confirms that the metrics settle at zero instead of growing.

// File: rtl/vit_acs_pkg.sv
// Shared definitions for the trellis path-metric unit.
// Assumes a rate 1/2 feedforward code; state bit M-1 is the newest input bit.
package vit_acs_pkg;

    typedef enum logic [1:0] {
        MODE_CONT  = 2'd0,
        MODE_TRUNC = 2'd1,
        MODE_TERM  = 2'd2
    } op_mode_e;

    // Parity of the bits of a small integer.
    function automatic int parity_of(input int v, input int nbits);
        int p;
        p = 0;
        for (int b = 0; b < nbits; b++) begin
            p = p ^ ((v >> b) & 1);
        end
        return p;
    endfunction

    // Coded pair {c0,c1} on the transition into next_state from the
    // predecessor whose oldest register bit is old_bit.
    function automatic int branch_code(input int next_state, input int old_bit,
                                       input int k, input int g0, input int g1);
        int regs;
        regs = (next_state << 1) | old_bit;
        return parity_of(regs & g0, k) * 2 + parity_of(regs & g1, k);
    endfunction

endpackage

// File: rtl/vit_acs_node.sv
// One add-compare-select cell: saturating add of two candidates, keep the
// smaller. Assumes SMW > BMW. Ties select candidate 0 (decision 0).
module vit_acs_node #(
    parameter int BMW = 4,
    parameter int SMW = 8
) (
    input  logic [SMW-1:0] pm0_i,
    input  logic [SMW-1:0] pm1_i,
    input  logic [BMW-1:0] bm0_i,
    input  logic [BMW-1:0] bm1_i,
    output logic [SMW-1:0] sel_o,
    output logic           dec_o
);
    localparam logic [SMW-1:0] MAXV = {SMW{1'b1}};

    logic [SMW:0]   sum0, sum1;
    logic [SMW-1:0] cand0, cand1;

    // Saturating additions of branch metric to predecessor metric.
    always_comb begin
        sum0  = {1'b0, pm0_i} + (SMW+1)'(bm0_i);
        sum1  = {1'b0, pm1_i} + (SMW+1)'(bm1_i);
        cand0 = sum0[SMW] ? MAXV : sum0[SMW-1:0];
        cand1 = sum1[SMW] ? MAXV : sum1[SMW-1:0];
    end

    // Compare and select; strict less-than makes ties pick candidate 0.
    always_comb begin
        dec_o = (cand1 < cand0);
        sel_o = dec_o ? cand1 : cand0;
    end

endmodule

// File: rtl/vit_metric_norm.sv
// Finds the smallest of NS metrics (lowest index on ties) and subtracts it
// from every metric that is not pinned at the maximum value.
module vit_metric_norm #(
    parameter int SMW = 8,
    parameter int NS  = 4,
    parameter int IW  = 2
) (
    input  logic [NS*SMW-1:0] raw_i,
    output logic [NS*SMW-1:0] norm_o,
    output logic [IW-1:0]     best_o
);
    localparam logic [SMW-1:0] MAXV = {SMW{1'b1}};

    logic [SMW-1:0] minv;

    // Linear scan for the minimum and its first index.
    always_comb begin
        minv   = raw_i[SMW-1:0];
        best_o = '0;
        for (int i = 1; i < NS; i++) begin
            if (raw_i[i*SMW +: SMW] < minv) begin
                minv   = raw_i[i*SMW +: SMW];
                best_o = IW'(i);
            end
        end
    end

    // Subtract the minimum; saturated states stay saturated.
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            if (raw_i[i*SMW +: SMW] == MAXV) begin
                norm_o[i*SMW +: SMW] = MAXV;
            end else begin
                norm_o[i*SMW +: SMW] = raw_i[i*SMW +: SMW] - minv;
            end
        end
    end

endmodule

// File: rtl/vit_acs_unit.sv
// Path-metric update unit for a rate 1/2 feedforward trellis with 2^(K-1)
// states. Per valid symbol: selects the predecessor metrics (stored or the
// initial pattern on a frame start / restart), runs one ACS cell per state,
// renormalises, and registers metrics, decisions and best state.
// Assumes SMW > BMW and branch metrics indexed by the coded pair {c0,c1}.
module vit_acs_unit
    import vit_acs_pkg::*;
#(
    parameter int K   = 3,
    parameter int BMW = 4,
    parameter int SMW = 8,
    parameter int G0  = 7,
    parameter int G1  = 5,
    localparam int M  = K - 1,
    localparam int NS = 1 << M
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [1:0]      mode_i,
    input  logic            frame_start_i,
    input  logic            restart_i,
    input  logic [4*BMW-1:0] bm_i,
    output logic            out_valid_o,
    output logic [NS-1:0]   dec_o,
    output logic [M-1:0]    best_o,
    output logic [NS*SMW-1:0] metrics_o
);
    localparam logic [SMW-1:0] MAXV = {SMW{1'b1}};

    logic [NS*SMW-1:0] init_w, pm_w, raw_w, norm_w, metric_q;
    logic [NS-1:0]     dec_w, dec_q;
    logic [M-1:0]      best_w, best_q;
    logic              vld_q, start_w;

    // Initial pattern: state 0 at zero, all others at the maximum.
    generate
        for (genvar s = 0; s < NS; s++) begin : g_init
            if (s == 0) begin : g_zero
                assign init_w[s*SMW +: SMW] = '0;
            end else begin : g_max
                assign init_w[s*SMW +: SMW] = MAXV;
            end
        end
    endgenerate

    // Reinitialisation request: restart in continuous mode, frame start otherwise.
    always_comb begin
        if (op_mode_e'(mode_i) == MODE_CONT) begin
            start_w = valid_i & restart_i;
        end else begin
            start_w = valid_i & frame_start_i;
        end
        pm_w = start_w ? init_w : metric_q;
    end

    // One ACS cell per next state with its predecessor pair and branch labels.
    generate
        for (genvar s = 0; s < NS; s++) begin : g_acs
            localparam int P0 = (s << 1) & (NS - 1);
            localparam int P1 = P0 | 1;
            localparam int C0 = branch_code(s, 0, K, G0, G1);
            localparam int C1 = branch_code(s, 1, K, G0, G1);

            vit_acs_node #(.BMW(BMW), .SMW(SMW)) i_node (
                .pm0_i (pm_w[P0*SMW +: SMW]),
                .pm1_i (pm_w[P1*SMW +: SMW]),
                .bm0_i (bm_i[C0*BMW +: BMW]),
                .bm1_i (bm_i[C1*BMW +: BMW]),
                .sel_o (raw_w[s*SMW +: SMW]),
                .dec_o (dec_w[s])
            );
        end
    endgenerate

    vit_metric_norm #(.SMW(SMW), .NS(NS), .IW(M)) i_norm (
        .raw_i  (raw_w),
        .norm_o (norm_w),
        .best_o (best_w)
    );

    // State register: metrics, decisions, best index and output valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            metric_q <= init_w;
            dec_q    <= '0;
            best_q   <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= valid_i;
            if (valid_i) begin
                metric_q <= norm_w;
                dec_q    <= dec_w;
                best_q   <= best_w;
            end
        end
    end

    assign out_valid_o = vld_q;
    assign dec_o       = dec_q;
    assign best_o      = best_q;
    assign metrics_o   = metric_q;

endmodule

// File: rtl/vit_acs_checker.sv
// Port-level properties of the path-metric unit, bound into every instance.
module vit_acs_checker #(
    parameter int K   = 3,
    parameter int BMW = 4,
    parameter int SMW = 8,
    localparam int M  = K - 1,
    localparam int NS = 1 << M
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [1:0]        mode_i,
    input logic              frame_start_i,
    input logic              restart_i,
    input logic [4*BMW-1:0]  bm_i,
    input logic              out_valid_o,
    input logic [NS-1:0]     dec_o,
    input logic [M-1:0]      best_o,
    input logic [NS*SMW-1:0] metrics_o
);
    localparam logic [SMW-1:0] MAXV = {SMW{1'b1}};

    logic              start_c;
    logic [NS-1:0]     zero_c;
    logic [NS*SMW-1:0] init_c, one_step_c;

    assign start_c = valid_i && ((mode_i == 2'd0) ? restart_i : frame_start_i);

    generate
        for (genvar s = 0; s < NS; s++) begin : g_s
            localparam int P0 = (s << 1) & (NS - 1);
            localparam int P1 = P0 | 1;
            assign zero_c[s] = (metrics_o[s*SMW +: SMW] == '0);
            assign init_c[s*SMW +: SMW] = (s == 0) ? '0 : MAXV;
            // Reachable in one step from state 0: only the input bit may be set.
            assign one_step_c[s*SMW +: SMW] = ((s & (NS/2 - 1)) == 0) ? '0 : MAXV;

            // R4: two saturated predecessors give a saturated state.
            a_r4_max_stays: assert property (@(posedge clk) disable iff (!rst_n)
                valid_i && !start_c && metrics_o[P0*SMW +: SMW] == MAXV
                && metrics_o[P1*SMW +: SMW] == MAXV
                |=> metrics_o[s*SMW +: SMW] == MAXV);
        end
    endgenerate

    // R1: first cycle out of reset shows the initial pattern.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (metrics_o == init_c) && !out_valid_o);

    // R3: from the initial pattern every decision is a tie or favours p0.
    a_r3_start_dec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> dec_o == '0);

    // R9 / R10: zero branch metrics from a restart leave only one-step states at zero.
    a_r9_start_zero_bm: assert property (@(posedge clk) disable iff (!rst_n)
        start_c && bm_i == '0 |=> metrics_o == one_step_c);

    // R5: some state always holds zero.
    a_r5_min_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> |zero_c);

    // R6: best index points at the first zero metric.
    a_r6_best_first_min: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> zero_c[best_o]
        && ((zero_c & ((NS'(1) << best_o) - NS'(1))) == '0));

    // R7: output valid follows input valid by one cycle.
    a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> out_valid_o);

    // R7: no symbol, no change.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(metrics_o) && !out_valid_o);

endmodule

bind vit_acs_unit vit_acs_checker #(.K(K), .BMW(BMW), .SMW(SMW)) i_chk (.*);

// File: tb/test_vit_acs_unit.sv
module test_vit_acs_unit;
    localparam int BMW = 4;
    localparam int SMW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        frame_start_i = 1'b0;
    logic        restart_i = 1'b0;
    logic [15:0] bm_i = '0;
    logic        out_valid_o;
    logic [3:0]  dec_o;
    logic [1:0]  best_o;
    logic [31:0] metrics_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] INIT_M = {8'd255, 8'd255, 8'd255, 8'd0};

    always #2 clk = ~clk;

    vit_acs_unit #(.BMW(BMW), .SMW(SMW)) i_vit_acs_unit (.*);

    // Row: mode[43:42] fs[41] rs[40] rx[39:38] dec[37:34] best[33:32] m3..m0[31:0]
    localparam logic [43:0] VEC [10] = '{
        {2'd0, 1'b0, 1'b0, 2'b11, 4'b0000, 2'd2, 8'd255, 8'd0, 8'd255, 8'd2},
        {2'd0, 1'b0, 1'b0, 2'b10, 4'b0000, 2'd1, 8'd2,   8'd3, 8'd0,   8'd3},
        {2'd0, 1'b0, 1'b0, 2'b00, 4'b1111, 2'd2, 8'd3,   8'd0, 8'd3,   8'd2},
        {2'd0, 1'b1, 1'b0, 2'b01, 4'b0000, 2'd3, 8'd0,   8'd3, 8'd2,   8'd3},
        {2'd0, 1'b0, 1'b0, 2'b11, 4'b1011, 2'd1, 8'd0,   8'd2, 8'd0,   8'd1},
        {2'd1, 1'b1, 1'b0, 2'b00, 4'b0000, 2'd0, 8'd255, 8'd2, 8'd255, 8'd0},
        {2'd1, 1'b0, 1'b0, 2'b01, 4'b0000, 2'd0, 8'd1,   8'd0, 8'd3,   8'd0},
        {2'd2, 1'b1, 1'b0, 2'b11, 4'b0000, 2'd2, 8'd255, 8'd0, 8'd255, 8'd2},
        {2'd2, 1'b0, 1'b1, 2'b10, 4'b0000, 2'd1, 8'd2,   8'd3, 8'd0,   8'd3},
        {2'd0, 1'b0, 1'b1, 2'b00, 4'b0000, 2'd0, 8'd255, 8'd2, 8'd255, 8'd0}
    };

    function automatic string row_tag(input int i);
        case (i)
            0: return "R2 R4";
            2: return "R3";
            3: return "R8";
            4: return "R5 R6";
            5, 6, 7: return "R9";
            8, 9: return "R10";
            default: return "R2";
        endcase
    endfunction

    // Hard-decision branch metrics: Hamming distance from each code to rx.
    function automatic logic [15:0] hamming_bm(input logic [1:0] rx);
        logic [15:0] v;
        for (int c = 0; c < 4; c++) begin
            v[c*4 +: 4] = 4'($countones(2'(c) ^ rx));
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] md, input logic fs, input logic rs,
                        input logic [15:0] bm);
        @(negedge clk);
        valid_i = 1'b1; mode_i = md; frame_start_i = fs; restart_i = rs; bm_i = bm;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(metrics_o == INIT_M, "R1 metrics in reset", metrics_o, INIT_M);
        chk(out_valid_o == 1'b0, "R1 out_valid in reset", 32'(out_valid_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(metrics_o == INIT_M, "R7 idle keeps metrics", metrics_o, INIT_M);

        // Table walk: one symbol per cycle.
        for (int i = 0; i < 10; i++) begin
            step(VEC[i][43:42], VEC[i][41], VEC[i][40], hamming_bm(VEC[i][39:38]));
            chk(metrics_o == VEC[i][31:0], {row_tag(i), " metrics"}, metrics_o, VEC[i][31:0]);
            chk(dec_o == VEC[i][37:34], {row_tag(i), " R3 decisions"}, 32'(dec_o), 32'(VEC[i][37:34]));
            chk(best_o == VEC[i][33:32], {row_tag(i), " R6 best"}, 32'(best_o), 32'(VEC[i][33:32]));
            chk(out_valid_o == 1'b1, "R7 out_valid after symbol", 32'(out_valid_o), 1);
        end

        // Idle after a symbol: valid drops, metrics hold.
        @(negedge clk);
        valid_i = 1'b0;
        @(posedge clk);
        #1;
        chk(out_valid_o == 1'b0, "R7 out_valid drops", 32'(out_valid_o), 0);
        chk(metrics_o == VEC[9][31:0], "R7 metrics hold", metrics_o, VEC[9][31:0]);

        // Long run of equal large branch metrics from a restart.
        step(2'd0, 1'b0, 1'b1, {4{4'd15}});
        chk(metrics_o == {8'd255, 8'd0, 8'd255, 8'd0}, "R5 first step normalised",
            metrics_o, {8'd255, 8'd0, 8'd255, 8'd0});
        for (int n = 0; n < 100; n++) begin
            step(2'd0, 1'b0, 1'b0, {4{4'd15}});
        end
        chk(metrics_o == 32'd0, "R5 no growth over long run", metrics_o, 0);
        chk(dec_o == 4'b0000, "R3 equal candidates pick p0", 32'(dec_o), 0);
        chk(best_o == 2'd0, "R6 lowest index on full tie", 32'(best_o), 0);

        // Reset while a symbol is offered.
        @(negedge clk);
        rst_n = 1'b0; valid_i = 1'b1; bm_i = hamming_bm(2'b01);
        @(posedge clk);
        #1;
        chk(metrics_o == INIT_M, "R1 reset beats valid", metrics_o, INIT_M);
        chk(out_valid_o == 1'b0, "R1 out_valid cleared", 32'(out_valid_o), 0);
        @(negedge clk);
        valid_i = 1'b0; rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule